// File: doc/BRIEF.md
# Idle and Standby Handshake Controller

This block handles module-level power for a subsystem that has one bus slave port and one bus master port. On the slave side it answers an idle request from a system power manager with an idle acknowledge. The answer depends on a programmed idle policy. On the master side it raises a standby request toward the power manager. The standby request follows a programmed standby policy, a software start bit, and a flag that shows whether master transactions are still outstanding.

Software sets the policies through a small configuration register. It also drives one clock-stop request per gateable sub-module and reads their acknowledges back. To enter idle, software raises the clock-stop requests, then sets the standby start bit, and then lets the power manager raise the idle request. When the block acknowledges, it drops both its functional and its interface clock enables. To leave idle, the power manager releases the request. The clock enables come back in the same cycle that the acknowledge falls, so software can then drop the clock-stop requests and write the no-standby policy.

Top module: `pwr_handshake_ctrl`

## Requirements
- R1: After a synchronous reset, the configuration readback is 0x0A. Both policies are smart and the start bit is clear. Also after reset: all clock-stop requests are low, idle_ack and stby_req are low, and both clock enables are high.
- R2: A write to the configuration register stores bits [1:0] as the idle policy, bits [3:2] as the standby policy and bit 4 as the standby start bit. The stored value appears on cfg_rdata one clock after the write edge. Acknowledges sampled on cs_ack appear on cs_ack_rd one clock later.
- R3: The policy code is 0 = force, 1 = none, 2 = smart. In smart idle, idle_ack rises one clock after a cycle in which idle_req is high, every cs_ack bit is high and the start bit is set. While any of these is missing, idle_ack stays low.
- R4: In force idle, idle_ack rises one clock after idle_req is seen high, whatever the clock-stop acknowledges and the start bit are.
- R5: In no-idle policy, idle_req is never acknowledged, and the clock enables stay high.
- R6: The reserved idle code 3 behaves exactly as smart idle.
- R7: stby_req is high one clock after a cycle in which the standby policy is force or smart (code 0, 2 or 3), the start bit is set and mst_busy is low. Otherwise it is low one clock later.
- R8: fclk_en and iclk_en are low exactly while idle_ack is high. They fall in the cycle idle_ack rises and return in the cycle it falls.
- R9: Once idle_req goes low, idle_ack is low one clock later.
- R10: A write to the clock-stop request register drives cs_req from the next clock onward. The request is held until it is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 5 | Configuration write data: idle policy [1:0], standby policy [3:2], start bit [4] |
| cfg_rdata | output | 5 | Registered configuration readback |
| cs_we | input | 1 | Clock-stop request register write strobe |
| cs_wdata | input | N_GATE | Clock-stop request write data, one bit per sub-module |
| cs_req | output | N_GATE | Clock-stop requests to the gateable sub-modules |
| cs_ack | input | N_GATE | Clock-stop acknowledges from the sub-modules |
| cs_ack_rd | output | N_GATE | Registered copy of cs_ack for software polling |
| idle_req | input | 1 | Idle request from the power manager |
| idle_ack | output | 1 | Idle acknowledge to the power manager |
| mst_busy | input | 1 | High while master transactions are outstanding |
| stby_req | output | 1 | Master standby request to the power manager |
| fclk_en | output | 1 | Functional clock enable |
| iclk_en | output | 1 | Interface clock enable |

## Verification
In smart idle, the last missing clock-stop acknowledge can arrive in the same cycle that idle_req rises. The bench drives both on one falling edge. It expects idle_ack high, and both enables low, after exactly one rising edge, and no earlier. A second collision happens on exit: the release of idle_req meets the restore of the clock enables. Here the bench checks that idle_ack is low and the enables are high together on the first sample after the release. A standby policy write is then made while idle is still being left, to show that stby_req follows the new policy one clock later.

// File: rtl/pwr_hs_pkg.sv
package pwr_hs_pkg;

  localparam int CFG_W     = 5;
  localparam int IMODE_LSB = 0;
  localparam int SMODE_LSB = 2;
  localparam int INIT_BIT  = 4;

  typedef enum logic [1:0] {
    PM_FORCE = 2'd0,
    PM_NONE  = 2'd1,
    PM_SMART = 2'd2,
    PM_RSVD  = 2'd3
  } pm_mode_e;

  localparam logic [CFG_W-1:0] CFG_RESET = {1'b0, PM_SMART, PM_SMART};

  // Reserved code folds onto smart.
  function automatic pm_mode_e pm_decode(input logic [1:0] code);
    if (code == 2'd3) return PM_SMART;
    return pm_mode_e'(code);
  endfunction

endpackage

// File: rtl/pwr_cfg_regs.sv
module pwr_cfg_regs
  import pwr_hs_pkg::*;
#(
  parameter int N_GATE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              cs_we,
  input  logic [N_GATE-1:0] cs_wdata,
  input  logic [N_GATE-1:0] cs_ack,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic [N_GATE-1:0] cs_ack_rd,
  output logic [N_GATE-1:0] cs_req,
  output pm_mode_e          idle_mode,
  output pm_mode_e          stby_mode,
  output logic              stby_init
);

  logic [CFG_W-1:0]  cfg_q;
  logic [N_GATE-1:0] csr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= CFG_RESET;
      csr_q     <= '0;
      cfg_rdata <= CFG_RESET;
      cs_ack_rd <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      if (cs_we)  csr_q <= cs_wdata;
      cfg_rdata <= cfg_q;
      cs_ack_rd <= cs_ack;
    end
  end

  assign cs_req    = csr_q;
  assign idle_mode = pm_decode(cfg_q[IMODE_LSB +: 2]);
  assign stby_mode = pm_decode(cfg_q[SMODE_LSB +: 2]);
  assign stby_init = cfg_q[INIT_BIT];

  // R10: a written request shows on the output after the write edge
  a_r10_cs_req_write: assert property (@(posedge clk) disable iff (rst)
    cs_we |=> (cs_req == $past(cs_wdata)));

  // R2: readback follows the stored value one clock later
  a_r2_cfg_readback: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> ##1 (cfg_rdata == $past(cfg_wdata, 2)));

endmodule

// File: rtl/pwr_idle_ctrl.sv
module pwr_idle_ctrl
  import pwr_hs_pkg::*;
#(
  parameter int N_GATE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_req,
  input  pm_mode_e          idle_mode,
  input  logic              stby_init,
  input  logic [N_GATE-1:0] cs_ack,
  output logic              idle_ack,
  output logic              fclk_en,
  output logic              iclk_en
);

  typedef enum logic {ST_RUN = 1'b0, ST_IDLE = 1'b1} idle_st_e;

  idle_st_e st_q, st_d;
  logic     grant;

  always_comb begin
    case (idle_mode)
      PM_FORCE: grant = 1'b1;
      PM_NONE:  grant = 1'b0;
      default:  grant = (&cs_ack) & stby_init;
    endcase
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RUN:  if (idle_req && grant) st_d = ST_IDLE;
      ST_IDLE: if (!idle_req)         st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_RUN;
      fclk_en <= 1'b1;
      iclk_en <= 1'b1;
    end else begin
      st_q    <= st_d;
      fclk_en <= (st_d == ST_RUN);
      iclk_en <= (st_d == ST_RUN);
    end
  end

  assign idle_ack = (st_q == ST_IDLE);

  // R4: force policy answers one clock after the request
  a_r4_force_ack: assert property (@(posedge clk) disable iff (rst)
    (idle_req && idle_mode == PM_FORCE) |=> idle_ack);

  // R5: no-idle policy never starts an acknowledge
  a_r5_none_holds: assert property (@(posedge clk) disable iff (rst)
    (!idle_ack && idle_mode == PM_NONE) |=> !idle_ack);

  // R3: smart policy waits for every acknowledge and the start bit
  a_r3_smart_wait: assert property (@(posedge clk) disable iff (rst)
    (!idle_ack && idle_mode == PM_SMART && !((&cs_ack) && stby_init)) |=> !idle_ack);

  // R9: release is seen one clock after the request drops
  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    !idle_req |=> !idle_ack);

  // R8: enables move together with the acknowledge
  a_r8_gate_on_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_ack) |-> (!fclk_en && !iclk_en));
  a_r8_restore: assert property (@(posedge clk) disable iff (rst)
    $fell(idle_ack) |-> (fclk_en && iclk_en));

endmodule

// File: rtl/pwr_stby_ctrl.sv
module pwr_stby_ctrl
  import pwr_hs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pm_mode_e stby_mode,
  input  logic     stby_init,
  input  logic     mst_busy,
  output logic     stby_req
);

  logic allow;

  always_comb begin
    case (stby_mode)
      PM_NONE: allow = 1'b0;
      default: allow = stby_init & ~mst_busy;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stby_req <= 1'b0;
    else     stby_req <= allow;
  end

  // R7: standby only follows a cycle with policy, start bit and an idle master
  a_r7_stby_cause: assert property (@(posedge clk) disable iff (rst)
    stby_req |-> $past(stby_mode != PM_NONE && stby_init && !mst_busy));
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    mst_busy |=> !stby_req);

endmodule

// File: rtl/pwr_handshake_ctrl.sv
module pwr_handshake_ctrl
  import pwr_hs_pkg::*;
#(
  parameter int N_GATE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_wdata,
  output logic [4:0]        cfg_rdata,
  input  logic              cs_we,
  input  logic [N_GATE-1:0] cs_wdata,
  output logic [N_GATE-1:0] cs_req,
  input  logic [N_GATE-1:0] cs_ack,
  output logic [N_GATE-1:0] cs_ack_rd,
  input  logic              idle_req,
  output logic              idle_ack,
  input  logic              mst_busy,
  output logic              stby_req,
  output logic              fclk_en,
  output logic              iclk_en
);

  pm_mode_e idle_mode;
  pm_mode_e stby_mode;
  logic     stby_init;

  pwr_cfg_regs #(.N_GATE(N_GATE)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cs_we     (cs_we),
    .cs_wdata  (cs_wdata),
    .cs_ack    (cs_ack),
    .cfg_rdata (cfg_rdata),
    .cs_ack_rd (cs_ack_rd),
    .cs_req    (cs_req),
    .idle_mode (idle_mode),
    .stby_mode (stby_mode),
    .stby_init (stby_init)
  );

  pwr_idle_ctrl #(.N_GATE(N_GATE)) u_idle (
    .clk       (clk),
    .rst       (rst),
    .idle_req  (idle_req),
    .idle_mode (idle_mode),
    .stby_init (stby_init),
    .cs_ack    (cs_ack),
    .idle_ack  (idle_ack),
    .fclk_en   (fclk_en),
    .iclk_en   (iclk_en)
  );

  pwr_stby_ctrl u_stby (
    .clk       (clk),
    .rst       (rst),
    .stby_mode (stby_mode),
    .stby_init (stby_init),
    .mst_busy  (mst_busy),
    .stby_req  (stby_req)
  );

  // R1: reset leaves the outputs in their run values
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!idle_ack && !stby_req && fclk_en && iclk_en && cs_req == '0));

endmodule

// File: tb/pwr_handshake_ctrl_test.sv
module pwr_handshake_ctrl_test;

  localparam int NG = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [4:0]    cfg_wdata = '0;
  logic [4:0]    cfg_rdata;
  logic          cs_we = 1'b0;
  logic [NG-1:0] cs_wdata = '0;
  logic [NG-1:0] cs_req;
  logic [NG-1:0] cs_ack = '0;
  logic [NG-1:0] cs_ack_rd;
  logic          idle_req = 1'b0;
  logic          idle_ack;
  logic          mst_busy = 1'b0;
  logic          stby_req;
  logic          fclk_en;
  logic          iclk_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_handshake_ctrl #(.N_GATE(NG)) uut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cs_we(cs_we), .cs_wdata(cs_wdata), .cs_req(cs_req),
    .cs_ack(cs_ack), .cs_ack_rd(cs_ack_rd),
    .idle_req(idle_req), .idle_ack(idle_ack),
    .mst_busy(mst_busy), .stby_req(stby_req),
    .fclk_en(fclk_en), .iclk_en(iclk_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one rising edge, then come back to the falling edge for sampling
  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr_cfg(input logic [4:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic wr_cs(input logic [NG-1:0] v);
    cs_we = 1'b1; cs_wdata = v;
    tick();
    cs_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cfg_rdata", cfg_rdata, 'h0A);
    chk("R1 cs_req", cs_req, 0);
    chk("R1 idle_ack", idle_ack, 0);
    chk("R1 stby_req", stby_req, 0);
    chk("R1 fclk_en", fclk_en, 1);
    chk("R1 iclk_en", iclk_en, 1);
  endtask

  task automatic t_regs();
    wr_cfg(5'h07);
    tick();
    chk("R2 cfg readback", cfg_rdata, 'h07);
    wr_cs(2'b11);
    chk("R10 cs_req", cs_req, 3);
    cs_ack = 2'b01;
    tick();
    chk("R2 ack readback", cs_ack_rd, 1);
    wr_cs(2'b10);
    tick(2);
    chk("R10 cs_req held", cs_req, 2);
    wr_cfg(5'h0A);
  endtask

  // smart idle entry, same-cycle arrival of last ack and request, then exit
  task automatic t_smart();
    wr_cs(2'b11);
    cs_ack = 2'b10;
    wr_cfg(5'h1A);
    idle_req = 1'b1;
    tick(2);
    chk("R3 smart waits for acks", idle_ack, 0);
    chk("R8 enable kept", fclk_en, 1);
    idle_req = 1'b0;
    tick();
    cs_ack = 2'b11;
    idle_req = 1'b1;
    chk("R3 not yet", idle_ack, 0);
    tick();
    chk("R3 smart ack", idle_ack, 1);
    chk("R8 fclk off", fclk_en, 0);
    chk("R8 iclk off", iclk_en, 0);
    idle_req = 1'b0;
    tick();
    chk("R9 ack released", idle_ack, 0);
    chk("R8 fclk back", fclk_en, 1);
    chk("R8 iclk back", iclk_en, 1);
    wr_cs(2'b00);
    cs_ack = 2'b00;
    wr_cfg(5'h16);
    tick();
    chk("R7 no-standby after exit", stby_req, 0);
  endtask

  task automatic t_smart_no_init();
    cs_ack = 2'b11;
    wr_cfg(5'h0A);
    idle_req = 1'b1;
    tick(3);
    chk("R3 start bit needed", idle_ack, 0);
    idle_req = 1'b0;
    tick();
  endtask

  task automatic t_force();
    cs_ack = 2'b00;
    wr_cfg(5'h08);
    idle_req = 1'b1;
    tick();
    chk("R4 force ack", idle_ack, 1);
    chk("R8 force gates", fclk_en, 0);
    idle_req = 1'b0;
    tick();
    chk("R9 force release", idle_ack, 0);
  endtask

  task automatic t_none();
    cs_ack = 2'b11;
    wr_cfg(5'h19);
    idle_req = 1'b1;
    tick(4);
    chk("R5 never acked", idle_ack, 0);
    chk("R5 clocks on", iclk_en, 1);
    idle_req = 1'b0;
    tick();
  endtask

  task automatic t_reserved();
    cs_ack = 2'b11;
    wr_cfg(5'h0B);
    idle_req = 1'b1;
    tick(2);
    chk("R6 reserved needs start bit", idle_ack, 0);
    wr_cfg(5'h1B);
    tick();
    chk("R6 reserved as smart", idle_ack, 1);
    idle_req = 1'b0;
    cs_ack = 2'b00;
    tick();
  endtask

  task automatic t_stby();
    mst_busy = 1'b1;
    wr_cfg(5'h1A);
    tick();
    chk("R7 busy blocks", stby_req, 0);
    mst_busy = 1'b0;
    tick();
    chk("R7 smart standby", stby_req, 1);
    wr_cfg(5'h16);
    tick();
    chk("R7 no standby", stby_req, 0);
    wr_cfg(5'h12);
    tick();
    chk("R7 force standby", stby_req, 1);
    wr_cfg(5'h02);
    tick();
    chk("R7 start bit clear", stby_req, 0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    t_reset();
    t_regs();
    t_smart();
    t_smart_no_init();
    t_force();
    t_none();
    t_reserved();
    t_stby();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule